// File: doc/BRIEF.md
# GPIO Edge Interrupt Front End

This block watches a bank of general-purpose input pins and turns their transitions into interrupt requests. Every pin can be armed separately for low-to-high transitions, for high-to-low transitions, or for both. Each pin goes through a two-stage synchroniser. A transition that is armed sets a sticky pending bit for that pin. Software clears a pending bit by writing a one to it.

The pins are split at a parameter `LOW_PINS`. Each pin below the split drives its own interrupt line. All pins at or above the split are ORed into one shared line. The handler for the shared line reads the pending register, writes the same value back, and repeats until the register reads zero. To mask a pin, software clears both of its arming bits. A small word-addressed register port gives access to the two arming registers and to the pending register.

Top module: `gpio_edge_irq`

## Requirements
- R1: After reset, both arming registers, the pending register, every `irq_low` line and `irq_high` are 0.
- R2: A pin whose rise-arm bit is 1 sets its pending bit when it goes from 0 to 1. A 0-to-1 transition on a pin whose rise-arm bit is 0 does not set it.
- R3: A pin whose fall-arm bit is 1 sets its pending bit when it goes from 1 to 0.
- R4: A pin with both arm bits set records transitions in both directions.
- R5: A write to the pending register (offset 0x8) clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R6: A write of 0x0FFFFFFF to the pending register clears all 28 pending bits.
- R7: A pin with both arm bits at 0 never sets its pending bit, whatever it does.
- R8: `irq_low[i]` equals pending bit i for every i below `LOW_PINS`.
- R9: `irq_high` is 1 exactly when any pending bit at index `LOW_PINS` or above is 1. Repeatedly writing the read value back to the pending register drives it to 0.
- R10: If an armed transition and a write-1 clear hit the same pending bit in the same cycle, the bit ends up 1.
- R11: The rise-arm register is at offset 0x0, the fall-arm register at 0x4 and the pending register at 0x8. Data is 32 bits wide, bits 31..28 read 0, and every other offset reads 0.
- R12: A pin level first sampled at clock edge k shows up in the pending register after edge k+2, and is not visible after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | NPINS | Asynchronous pin levels |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for `bus_addr`, combinational |
| irq_low | output | LOW_PINS | Dedicated interrupts for the low pins |
| irq_high | output | 1 | Shared interrupt for the high pins |

## Verification
The assertions assume that `bus_wr`, `bus_addr` and `bus_wdata` are known and stable at every rising clock edge. They also assume that the only thing that ever sets a pending bit is a transition seen by the synchroniser. The bench changes pins and bus signals only one nanosecond after a rising edge, so every sampled value is settled. The offsets it uses are word-aligned or deliberately unmapped. Random pin activity runs alongside random register writes, so transitions and clears often land in the same cycle.

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq #(
  parameter int NPINS    = 28,
  parameter int LOW_PINS = 8,
  parameter int DW       = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NPINS-1:0]    pin_in,
  input  logic                bus_wr,
  input  logic [3:0]          bus_addr,
  input  logic [DW-1:0]       bus_wdata,
  output logic [DW-1:0]       bus_rdata,
  output logic [LOW_PINS-1:0] irq_low,
  output logic                irq_high
);
  localparam logic [3:0] OFS_RISE = 4'h0;
  localparam logic [3:0] OFS_FALL = 4'h4;
  localparam logic [3:0] OFS_PEND = 4'h8;

  logic [NPINS-1:0] sync_a, sync_b, last;
  logic [NPINS-1:0] rise_arm, fall_arm, pend;
  logic [NPINS-1:0] hit, clr;

  assign hit = (sync_b & ~last & rise_arm) | (~sync_b & last & fall_arm);
  assign clr = (bus_wr && bus_addr == OFS_PEND) ? bus_wdata[NPINS-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_a <= '0;
      sync_b <= '0;
      last   <= '0;
    end else begin
      sync_a <= pin_in;
      sync_b <= sync_a;
      last   <= sync_b;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_arm <= '0;
      fall_arm <= '0;
    end else if (bus_wr) begin
      if (bus_addr == OFS_RISE) rise_arm <= bus_wdata[NPINS-1:0];
      if (bus_addr == OFS_FALL) fall_arm <= bus_wdata[NPINS-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else        pend <= (pend & ~clr) | hit;
  end

  always_comb begin
    case (bus_addr)
      OFS_RISE: bus_rdata = DW'(rise_arm);
      OFS_FALL: bus_rdata = DW'(fall_arm);
      OFS_PEND: bus_rdata = DW'(pend);
      default:  bus_rdata = '0;
    endcase
  end

  assign irq_low  = pend[LOW_PINS-1:0];
  assign irq_high = |pend[NPINS-1:LOW_PINS];

  // R5
  pend_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pend) & ~pend & ~$past(clr)) == '0);

  // R7
  unarmed_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend & ~$past(pend) & ~($past(rise_arm) | $past(fall_arm))) == '0);

  // R6
  clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_PEND && (&bus_wdata[NPINS-1:0]))
      |=> (pend & ~$past(hit)) == '0);

  // R10
  hit_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend & $past(hit)) == $past(hit));
endmodule

// File: tb/gpio_edge_irq_bench.sv
`timescale 1ns/1ps
module gpio_edge_irq_bench;
  localparam int N = 28;
  localparam int L = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] pins = '0;
  logic bus_wr = 1'b0;
  logic [3:0] bus_addr = 4'h0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [L-1:0] irq_low;
  logic irq_high;

  int checks = 0;
  int errors = 0;
  bit chk_on = 0;

  always #2.5 clk = ~clk;

  gpio_edge_irq #(.NPINS(N), .LOW_PINS(L), .DW(32)) u_gpio_edge_irq (
    .clk(clk), .rst_n(rst_n), .pin_in(pins), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_low(irq_low), .irq_high(irq_high));

  // behavioural reference
  bit [N-1:0] m_rise, m_fall, m_pend, m_hits, m_clr, m_now, m_old;
  bit [N-1:0] hist[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_rise = '0; m_fall = '0; m_pend = '0;
      hist.delete();
      for (int i = 0; i < 3; i++) hist.push_back('0);
    end else begin
      m_now  = hist[1];
      m_old  = hist[2];
      m_hits = '0;
      for (int i = 0; i < N; i++) begin
        if (m_now[i] && !m_old[i] && m_rise[i]) m_hits[i] = 1'b1;
        if (!m_now[i] && m_old[i] && m_fall[i]) m_hits[i] = 1'b1;
      end
      m_clr  = (bus_wr && bus_addr == 4'h8) ? bus_wdata[N-1:0] : '0;
      m_pend = (m_pend & ~m_clr) | m_hits;
      if (bus_wr && bus_addr == 4'h0) m_rise = bus_wdata[N-1:0];
      if (bus_wr && bus_addr == 4'h4) m_fall = bus_wdata[N-1:0];
      hist.push_front(pins);
      void'(hist.pop_back());
    end
  end

  function automatic logic [31:0] m_read(input logic [3:0] a);
    case (a)
      4'h0: return {4'h0, m_rise};
      4'h4: return {4'h0, m_fall};
      4'h8: return {4'h0, m_pend};
      default: return 32'h0;
    endcase
  endfunction

  task automatic expect_eq(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on) begin
      expect_eq(32'(irq_low), 32'(m_pend[L-1:0]), "R8 irq_low vs model");
      expect_eq(32'(irq_high), 32'(|m_pend[N-1:L]), "R9 irq_high vs model");
      expect_eq(bus_rdata, m_read(bus_addr), "R11 read data vs model");
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
    @(posedge clk); #1;
    bus_addr = a;
    @(negedge clk);
    expect_eq(bus_rdata, exp, tag);
  endtask

  task automatic setp(input logic [N-1:0] v);
    @(posedge clk); #1;
    pins = v;
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    chk_on = 1;
    // R1
    rd(4'h0, 32'h0, "R1 rise-arm after reset");
    rd(4'h4, 32'h0, "R1 fall-arm after reset");
    rd(4'h8, 32'h0, "R1 pending after reset");
    expect_eq(32'(irq_low), 32'h0, "R1 irq_low after reset");
    expect_eq(32'(irq_high), 32'h0, "R1 irq_high after reset");

    // R2
    wr(4'h0, 32'h0010_0003);
    wr(4'h4, 32'h0800_0006);
    setp(28'h010_0007);
    repeat (2) @(posedge clk);
    rd(4'h8, 32'h0010_0003, "R2 rising edges on armed pins only");
    expect_eq(32'(irq_low), 32'h03, "R8 dedicated lines follow pending");
    expect_eq(32'(irq_high), 32'h1, "R9 shared line for pin 20");

    // R5
    wr(4'h8, 32'h0000_0001);
    rd(4'h8, 32'h0010_0002, "R5 write-one clears only selected bit");

    // R6
    wr(4'h8, 32'h0FFF_FFFF);
    rd(4'h8, 32'h0, "R6 clear all pending");
    expect_eq(32'(irq_high), 32'h0, "R9 shared line drops after clear");

    // R3
    setp(28'h010_0001);
    repeat (2) @(posedge clk);
    rd(4'h8, 32'h0000_0006, "R3 falling edges on pins 1 and 2");

    // R4
    wr(4'h8, 32'hFFFF_FFFF);
    setp(28'h010_0003);
    repeat (2) @(posedge clk);
    rd(4'h8, 32'h0000_0002, "R4 pin 1 rise with both arms");

    // R7
    wr(4'h0, 32'h0);
    wr(4'h4, 32'h0);
    wr(4'h8, 32'h0FFF_FFFF);
    setp(~pins);
    repeat (3) @(posedge clk);
    setp(~pins);
    repeat (3) @(posedge clk);
    rd(4'h8, 32'h0, "R7 unarmed pins never set pending");

    // R10
    wr(4'h0, 32'h0000_0008);
    setp(pins & ~28'h8);
    repeat (3) @(posedge clk);
    setp(pins | 28'h8);
    repeat (2) @(posedge clk);
    rd(4'h8, 32'h0000_0008, "R10 setup pin 3 pending");
    setp(pins & ~28'h8);
    repeat (3) @(posedge clk);
    @(posedge clk); #1 pins = pins | 28'h8;
    @(posedge clk); #1;
    @(posedge clk); #1 bus_wr = 1'b1; bus_addr = 4'h8; bus_wdata = 32'h8;
    @(posedge clk); #1 bus_wr = 1'b0;
    @(negedge clk);
    expect_eq(bus_rdata, 32'h0000_0008, "R10 edge wins over same-cycle clear");

    // R12
    wr(4'h8, 32'h0FFF_FFFF);
    wr(4'h0, 32'h0000_0010);
    setp(pins & ~28'h10);
    repeat (3) @(posedge clk);
    #1 bus_addr = 4'h8;
    @(posedge clk); #1 pins = pins | 28'h10;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    expect_eq(bus_rdata & 32'h10, 32'h0, "R12 not visible after second edge");
    @(negedge clk);
    expect_eq(bus_rdata & 32'h10, 32'h10, "R12 visible after third edge");

    // R11
    wr(4'h0, 32'hFFFF_FFFF);
    rd(4'h0, 32'h0FFF_FFFF, "R11 upper bits read zero");
    rd(4'h4, 32'h0, "R11 fall-arm at offset 4 untouched");
    rd(4'hC, 32'h0, "R11 unmapped offset reads zero");
    rd(4'h1, 32'h0, "R11 misaligned offset reads zero");

    // random traffic against the model
    wr(4'h4, 32'h0FFF_FFFF);
    for (int c = 0; c < 3000; c++) begin
      @(posedge clk); #1;
      if ($urandom_range(0, 2) == 0) pins = pins ^ N'(1 << $urandom_range(0, N - 1));
      bus_wr = ($urandom_range(0, 7) == 0);
      case ($urandom_range(0, 3))
        0: bus_addr = 4'h0;
        1: bus_addr = 4'h4;
        2: bus_addr = 4'h8;
        default: bus_addr = 4'hC;
      endcase
      bus_wdata = $urandom;
    end
    @(posedge clk); #1 bus_wr = 1'b0;

    // R9 service loop for the shared line
    wr(4'h0, 32'h0);
    wr(4'h4, 32'h0);
    for (int k = 0; k < 8; k++) begin
      @(posedge clk); #1 bus_addr = 4'h8;
      @(negedge clk);
      v = bus_rdata;
      if (v != 0) wr(4'h8, v);
    end
    rd(4'h8, 32'h0, "R9 read-write-back loop empties pending");
    expect_eq(32'(irq_high), 32'h0, "R9 shared line idle after service");

    summary();
    $finish;
  end
endmodule